// File: doc/BRIEF.md
# Load-PC Stride Prefetcher

This block watches the stream of load instructions and learns, for each load, the distance between successive addresses it touches. A small direct-mapped table, selected by the low bits of the load's program counter, keeps per load a tag, the most recent block address, a learned stride and a two-bit confidence counter. After a load has shown a consistent nonzero stride often enough, each further execution of that load sends one or more cache-block prefetch addresses downstream. These addresses lie several strides ahead of the current access, so that the fetch can arrive before the load needs it.

Addresses on the observation port are already cache-block addresses; the byte offset is removed upstream. Two configuration inputs set how far ahead the first prefetch lands (the lookahead multiple) and how many prefetches one trigger produces. Prefetches leave on a valid/ready stream, one per accepted handshake. A trigger that arrives while an earlier burst is still being sent is discarded, but the table still learns from that load.

Top module: `ldstride_pf`

## Requirements
- R1: After reset, every table entry is invalid and `pf_valid` is low until a triggering observation is accepted.
- R2: The table slot is chosen by the low 4 bits of `obs_pc`, and the remaining PC bits form the tag. A tag miss or an invalid slot rewrites the slot with the new tag and address, stride 0 and confidence 0, and issues no prefetch.
- R3: On a tag hit the observed stride is `obs_addr` minus the stored address (modulo 2^ADDR_W), and the stored address becomes `obs_addr`. The stored stride is replaced by the observed stride only when the prior confidence is 0 and the two differ.
- R4: Confidence is a saturating count from 0 to 3: it goes up by one when the observed stride equals the stored stride and down by one (never below 0) otherwise. A trigger needs the updated confidence to be 2 or more.
- R5: No prefetch is issued when the updated stride is zero, whatever the confidence.
- R6: The first prefetch of a trigger is `obs_addr + (cfg_ahead + 1) * stride` (modulo 2^ADDR_W), using the updated stride.
- R7: One trigger produces exactly `cfg_degree + 1` prefetches, each one stride beyond the previous.
- R8: While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_addr` does not change; at most one prefetch leaves per cycle.
- R9: A trigger that arrives while a burst is still pending is dropped without altering the pending burst, yet the table entry is updated as for any hit.
- R10: Two loads whose PCs share the low 4 bits evict each other, so a load must re-train from confidence 0 after being evicted.
- R11: The first prefetch of an accepted trigger is presented on the cycle right after the observation is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| obs_valid | input | 1 | A load observation is present this cycle |
| obs_pc | input | PC_W | Program counter of the observed load |
| obs_addr | input | ADDR_W | Cache-block address the load referenced |
| cfg_ahead | input | AHEAD_W | Lookahead multiple minus one |
| cfg_degree | input | DEG_W | Number of prefetches per trigger minus one |
| pf_valid | output | 1 | A prefetch address is offered |
| pf_ready | input | 1 | Downstream accepts the offered prefetch |
| pf_addr | output | ADDR_W | Prefetch cache-block address |

## Verification
The table update and the load of the issue queue both happen on the clock edge that samples the observation, so the first prefetch of a trigger is due one cycle later and each following one a cycle after the previous handshake. The bench drives inputs and reads outputs on falling edges: it applies an observation on one falling edge, reads the first prefetch on the next one, and then reads one address per cycle while ready is held high. A bench-side model of the table, written from the requirements, predicts whether each observation triggers and which addresses follow. Backpressure and dropped triggers are checked by holding ready low for several cycles and then reading the burst that follows.

// File: rtl/ldstride_pkg.sv
`timescale 1ns/1ps
package ldstride_pkg;
  typedef logic [1:0] conf_t;
  localparam conf_t CONF_MAX   = 2'd3;
  localparam conf_t CONF_FIRE  = 2'd2;
  localparam conf_t CONF_ZERO  = 2'd0;
endpackage

// File: rtl/ldstride_table.sv
`timescale 1ns/1ps
module ldstride_table
  import ldstride_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              obs_valid,
  input  logic [PC_W-1:0]   obs_pc,
  input  logic [ADDR_W-1:0] obs_addr,
  output logic              trig,
  output logic [ADDR_W-1:0] trig_addr,
  output logic [ADDR_W-1:0] trig_stride
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [ADDR_W-1:0] last;
    logic [ADDR_W-1:0] stride;
    conf_t             conf;
  } slot_t;

  logic [ENTRIES-1:0] vld_q;
  slot_t              slot_q [ENTRIES];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag_in;
  slot_t             cur;
  slot_t             wr_slot;
  logic              hit;
  logic [ADDR_W-1:0] delta;
  logic              same;
  conf_t             conf_n;
  logic [ADDR_W-1:0] stride_n;

  // next-state logic
  always_comb begin
    idx      = obs_pc[IDX_W-1:0];
    tag_in   = obs_pc[PC_W-1:IDX_W];
    cur      = slot_q[idx];
    hit      = vld_q[idx] && (cur.tag == tag_in);
    delta    = obs_addr - cur.last;
    same     = (delta == cur.stride);
    if (same)
      conf_n = (cur.conf == CONF_MAX) ? CONF_MAX : cur.conf + 2'd1;
    else
      conf_n = (cur.conf == CONF_ZERO) ? CONF_ZERO : cur.conf - 2'd1;
    stride_n = (!same && cur.conf == CONF_ZERO) ? delta : cur.stride;

    wr_slot.tag    = tag_in;
    wr_slot.last   = obs_addr;
    wr_slot.stride = hit ? stride_n : '0;
    wr_slot.conf   = hit ? conf_n : CONF_ZERO;

    trig        = obs_valid && hit && (conf_n >= CONF_FIRE) && (stride_n != '0);
    trig_addr   = obs_addr;
    trig_stride = stride_n;
  end

  // valid bits carry reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      vld_q <= '0;
    else if (obs_valid)
      vld_q[idx] <= 1'b1;
  end

  // slot payload, written under clock enable, no reset
  always_ff @(posedge clk) begin
    if (obs_valid)
      slot_q[idx] <= wr_slot;
  end
endmodule

// File: rtl/ldstride_issue.sv
`timescale 1ns/1ps
module ldstride_issue #(
  parameter int ADDR_W  = 32,
  parameter int AHEAD_W = 3,
  parameter int DEG_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig,
  input  logic [ADDR_W-1:0]  trig_addr,
  input  logic [ADDR_W-1:0]  trig_stride,
  input  logic [AHEAD_W-1:0] cfg_ahead,
  input  logic [DEG_W-1:0]   cfg_degree,
  input  logic               pf_ready,
  output logic               pf_valid,
  output logic [ADDR_W-1:0]  pf_addr,
  output logic               busy
);
  logic              busy_q, busy_n;
  logic [ADDR_W-1:0] cur_q, cur_n;
  logic [ADDR_W-1:0] step_q, step_n;
  logic [DEG_W-1:0]  left_q, left_n;
  logic              load, fire;
  logic [ADDR_W-1:0] mult;

  always_comb begin
    load   = trig && !busy_q;
    fire   = busy_q && pf_ready;
    mult   = ADDR_W'(cfg_ahead) + ADDR_W'(1);
    busy_n = busy_q;
    cur_n  = cur_q;
    step_n = step_q;
    left_n = left_q;
    if (load) begin
      busy_n = 1'b1;
      cur_n  = trig_addr + mult * trig_stride;
      step_n = trig_stride;
      left_n = cfg_degree;
    end else if (fire) begin
      if (left_q == '0) begin
        busy_n = 1'b0;
      end else begin
        left_n = left_q - 1'b1;
        cur_n  = cur_q + step_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      busy_q <= 1'b0;
    else
      busy_q <= busy_n;
  end

  always_ff @(posedge clk) begin
    if (load || fire) begin
      cur_q  <= cur_n;
      step_q <= step_n;
      left_q <= left_n;
    end
  end

  assign pf_valid = busy_q;
  assign pf_addr  = cur_q;
  assign busy     = busy_q;
endmodule

// File: rtl/ldstride_pf.sv
`timescale 1ns/1ps
module ldstride_pf #(
  parameter int PC_W    = 32,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 4,
  parameter int AHEAD_W = 3,
  parameter int DEG_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               obs_valid,
  input  logic [PC_W-1:0]    obs_pc,
  input  logic [ADDR_W-1:0]  obs_addr,
  input  logic [AHEAD_W-1:0] cfg_ahead,
  input  logic [DEG_W-1:0]   cfg_degree,
  output logic               pf_valid,
  input  logic               pf_ready,
  output logic [ADDR_W-1:0]  pf_addr
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              t_trig;
  logic [ADDR_W-1:0] t_addr;
  logic [ADDR_W-1:0] t_stride;
  logic              issue_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ldstride_table #(
    .PC_W(PC_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_table (
    .clk(clk), .rst_n(rst_int_n),
    .obs_valid(obs_valid), .obs_pc(obs_pc), .obs_addr(obs_addr),
    .trig(t_trig), .trig_addr(t_addr), .trig_stride(t_stride)
  );

  ldstride_issue #(
    .ADDR_W(ADDR_W), .AHEAD_W(AHEAD_W), .DEG_W(DEG_W)
  ) u_issue (
    .clk(clk), .rst_n(rst_int_n),
    .trig(t_trig), .trig_addr(t_addr), .trig_stride(t_stride),
    .cfg_ahead(cfg_ahead), .cfg_degree(cfg_degree),
    .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr),
    .busy(issue_busy)
  );
endmodule

// File: rtl/ldstride_chk.sv
`timescale 1ns/1ps
module ldstride_chk #(
  parameter int ADDR_W = 32,
  parameter int DEG_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              obs_valid,
  input logic              trig,
  input logic              busy,
  input logic [DEG_W-1:0]  cfg_degree,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_addr
);
  logic [DEG_W:0] sent_q;
  logic [DEG_W:0] lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q <= '0;
      lim_q  <= '0;
    end else if (trig && !busy) begin
      sent_q <= '0;
      lim_q  <= {1'b0, cfg_degree} + 1'b1;
    end else if (pf_valid && pf_ready) begin
      sent_q <= sent_q + 1'b1;
    end
  end

  // R8
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

  // R11
  accept_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig && !busy |=> pf_valid);

  // R1
  no_spont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(obs_valid) && !$past(pf_valid) |-> !pf_valid);

  // R7
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sent_q <= lim_q);

  // R9
  drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig && busy && !pf_ready |=> $stable(pf_addr));
endmodule

bind ldstride_pf ldstride_chk #(.ADDR_W(ADDR_W), .DEG_W(DEG_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .obs_valid(obs_valid),
  .trig(t_trig), .busy(issue_busy), .cfg_degree(cfg_degree),
  .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
);

// File: tb/test_ldstride_pf.sv
`timescale 1ns/1ps
module test_ldstride_pf;
  localparam int PC_W = 32, ADDR_W = 32, IDX_W = 4, AHEAD_W = 3, DEG_W = 2;
  localparam int ENT = 1 << IDX_W;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               obs_valid;
  logic [PC_W-1:0]    obs_pc;
  logic [ADDR_W-1:0]  obs_addr;
  logic [AHEAD_W-1:0] cfg_ahead;
  logic [DEG_W-1:0]   cfg_degree;
  logic               pf_valid;
  logic               pf_ready;
  logic [ADDR_W-1:0]  pf_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ldstride_pf #(.PC_W(PC_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
                .AHEAD_W(AHEAD_W), .DEG_W(DEG_W)) i_ldstride_pf (
    .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_pc(obs_pc),
    .obs_addr(obs_addr), .cfg_ahead(cfg_ahead), .cfg_degree(cfg_degree),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr));

  // reference table built from the requirements
  bit                m_vld  [ENT];
  logic [PC_W-1:0]   m_pc   [ENT];
  logic [ADDR_W-1:0] m_last [ENT];
  logic [ADDR_W-1:0] m_str  [ENT];
  int                m_conf [ENT];
  bit                e_trig;
  logic [ADDR_W-1:0] e_base;
  logic [ADDR_W-1:0] e_str;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_obs(input logic [PC_W-1:0] pc, input logic [ADDR_W-1:0] a);
    int i = int'(pc[IDX_W-1:0]);
    logic [ADDR_W-1:0] d;
    int c;
    logic [ADDR_W-1:0] s;
    e_trig = 0;
    if (m_vld[i] && m_pc[i][PC_W-1:IDX_W] == pc[PC_W-1:IDX_W]) begin
      d = a - m_last[i];
      if (d == m_str[i]) c = (m_conf[i] == 3) ? 3 : m_conf[i] + 1;
      else               c = (m_conf[i] == 0) ? 0 : m_conf[i] - 1;
      s = (d != m_str[i] && m_conf[i] == 0) ? d : m_str[i];
      m_str[i] = s; m_conf[i] = c;
      e_trig = (c >= 2) && (s != 0);
      e_base = a; e_str = s;
    end else begin
      m_vld[i] = 1; m_pc[i] = pc; m_str[i] = 0; m_conf[i] = 0;
    end
    m_last[i] = a;
  endtask

  task automatic drive_obs(input logic [PC_W-1:0] pc, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    obs_valid = 1; obs_pc = pc; obs_addr = a;
    model_obs(pc, a);
    @(negedge clk);
    obs_valid = 0;
  endtask

  // called on the falling edge right after the observation edge, ready high
  task automatic collect(input string req);
    logic [ADDR_W-1:0] exp;
    if (e_trig) begin
      exp = e_base + (ADDR_W'(cfg_ahead) + 1) * e_str;
      for (int k = 0; k <= int'(cfg_degree); k++) begin
        check(pf_valid == 1, (k == 0) ? "R11 first valid" : "R7 burst valid",
              32'(pf_valid), 1);
        check(pf_addr == exp, (k == 0) ? {req, " R6 target"} : {req, " R7 step"},
              pf_addr, exp);
        exp = exp + e_str;
        @(negedge clk);
      end
      check(pf_valid == 0, "R7 burst end", 32'(pf_valid), 0);
    end else begin
      check(pf_valid == 0, {req, " no prefetch"}, 32'(pf_valid), 0);
    end
  endtask

  task automatic step(input logic [PC_W-1:0] pc, input logic [ADDR_W-1:0] a,
                      input string req);
    drive_obs(pc, a);
    collect(req);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] a;
    logic [ADDR_W-1:0] hold;
    logic [ADDR_W-1:0] exp;
    for (int i = 0; i < ENT; i++) begin m_vld[i] = 0; m_conf[i] = 0; end
    rst_n = 0; obs_valid = 0; obs_pc = '0; obs_addr = '0;
    cfg_ahead = '0; cfg_degree = '0; pf_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(pf_valid == 0, "R1 reset idle", 32'(pf_valid), 0);

    // R2/R4: training needs four accesses; the first three must be silent
    cfg_ahead = 0; cfg_degree = 0;
    step(32'h0000_1003, 32'h100, "R2 alloc");
    step(32'h0000_1003, 32'h104, "R4 conf0");
    step(32'h0000_1003, 32'h108, "R4 conf1");
    step(32'h0000_1003, 32'h10C, "R4 conf2");

    // R6/R7 sweep: every lookahead and degree, varied strides
    for (int ah = 0; ah < 8; ah++) begin
      for (int dg = 0; dg < 4; dg++) begin
        logic [ADDR_W-1:0] st;
        logic [PC_W-1:0] pc;
        cfg_ahead = AHEAD_W'(ah); cfg_degree = DEG_W'(dg);
        st = ((ah + dg) % 2 == 0) ? ADDR_W'(ah * 4 + dg + 1) : -ADDR_W'(dg * 3 + 2);
        pc = PC_W'(32'h0004_0000 + ah * 64 + dg * 16 + ((ah * 4 + dg) % ENT));
        a = ADDR_W'(32'h0010_0000 + ah * 4096 + dg * 256);
        for (int n = 0; n < 6; n++) begin
          step(pc, a, "R6 sweep");
          a = a + st;
        end
      end
    end

    // R5: zero stride never prefetches
    cfg_ahead = 1; cfg_degree = 1;
    for (int n = 0; n < 5; n++) step(32'h0000_2005, 32'h500, "R5 zero stride");

    // R3: one off-stride access at confidence 3 keeps the stride
    cfg_ahead = 0; cfg_degree = 0;
    a = 32'h9000;
    for (int n = 0; n < 5; n++) begin step(32'h0000_3006, a, "R3 train"); a += 8; end
    step(32'h0000_3006, a + 100, "R3 off stride kept");
    step(32'h0000_3006, a + 108, "R3 resume");

    // R10: aliasing loads evict each other
    a = 32'h2_0000;
    for (int n = 0; n < 4; n++) begin step(32'h0000_4007, a, "R10 train"); a += 2; end
    step(32'h0000_4017, 32'h7000, "R10 alias alloc");
    step(32'h0000_4007, a, "R10 evicted");
    a += 2;
    step(32'h0000_4007, a, "R10 retrain");

    // R8/R9: backpressure and dropped trigger
    a = 32'h3_0000;
    for (int n = 0; n < 4; n++) begin step(32'h0000_5008, a, "R8 train"); a += 4; end
    hold = 32'h4_0000;
    for (int n = 0; n < 4; n++) begin step(32'h0000_6009, hold, "R9 train"); hold += 16; end
    cfg_ahead = 1; cfg_degree = 2;
    pf_ready = 0;
    drive_obs(32'h0000_5008, a);
    exp = a + 2 * 4;
    for (int n = 0; n < 3; n++) begin
      check(pf_valid == 1 && pf_addr == exp, "R8 hold", pf_addr, exp);
      @(negedge clk);
    end
    drive_obs(32'h0000_6009, hold);  // arrives while busy: dropped
    hold += 16;
    check(pf_valid == 1 && pf_addr == exp, "R9 pending kept", pf_addr, exp);
    pf_ready = 1;
    for (int k = 0; k < 3; k++) begin
      check(pf_valid == 1 && pf_addr == exp, "R8 release", pf_addr, exp);
      exp += 4;
      @(negedge clk);
    end
    check(pf_valid == 0, "R9 dropped burst absent", 32'(pf_valid), 0);
    cfg_ahead = 0; cfg_degree = 0;
    step(32'h0000_6009, hold, "R9 table updated");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule